// File: doc/BRIEF.md
# Eight-bit PWM Timer/Counter

This block is an 8-bit counter that advances only on cycles where a prescale tick enable is high. A two-bit counting mode picks one of four behaviours: plain free-running count, clear-on-compare (channel A value sets the period), single-slope fast PWM, and dual-slope phase-correct PWM. Two compare channels, A and B, each hold a compare value and drive one waveform output with its own output enable. Each channel's waveform action is chosen by a two-bit output mode.

Software writes a simple register bus. Address 0 is the control register. Address 1 is the channel A compare value. Address 2 is the channel B compare value. Address 3 clears flags: writing a one to a bit position clears that flag. An overflow flag and two compare-match flags report counter events. They stay set until software clears them.

In the PWM modes, a written compare value first waits in a shadow register. It becomes active only at the mode's update point. This prevents glitches in the middle of a period. In the other modes, the write takes effect at once.

Top module: `pwm_timer8`

## Requirements
- R1: The control register (bus address 0) resets to 0. Its bits 1:0 hold the counting mode (0 normal, 1 phase-correct, 2 clear-on-compare, 3 fast PWM). Bits 7:6 hold the channel A output mode. Bits 5:4 hold the channel B output mode. After reset, the count, all flags, both waveforms and both enables read 0.
- R2: The count changes only on clock edges where `tick` is high.
- R3: In mode 0, the count runs 0 up to 0xFF and wraps to 0. The overflow flag (flag bit 0) is set by the tick taken at count 0xFF.
- R4: In mode 2, the tick taken while the count equals the active channel A compare value returns the count to 0. The overflow flag is set only by a tick taken at 0xFF.
- R5: In mode 3, the count runs up and wraps like mode 0. The overflow flag is set by the tick at 0xFF. Shadowed compare values become active on that same wrapping tick.
- R6: In mode 1, the count runs up from 0 to 0xFF and then down to 0. After 0xFF the next value is 0xFE; after 0 going down the next value is 1. Shadowed compare values become active on the tick at 0xFF. The overflow flag is set by the tick taken at 0 while counting down.
- R7: In modes 0 and 2, a compare write (address 1 for A, address 2 for B) becomes active on the clock edge that performs the write.
- R8: A channel's match flag (bit 1 for A, bit 2 for B) is set by a tick taken while the count equals that channel's active compare value. Writing 1s to address 3 clears the flags at those bit positions and leaves the others unchanged. A flag being set in the same cycle wins over a clear.
- R9: With output mode 0, the channel's waveform and enable both read 0, although match flags still set. Output mode 1 toggles the waveform on each match in every counting mode. Any nonzero output mode drives the enable high.
- R10: In modes 0 and 2, output mode 2 clears the waveform on a match and output mode 3 sets it.
- R11: In mode 3, output mode 2 sets the waveform on the wrapping tick and clears it on a match. Output mode 3 does the reverse. When both events fall on the same tick, the wrap action wins.
- R12: In mode 1, output mode 2 clears the waveform on a match while counting up and sets it on a match while counting down. Output mode 3 does the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Prescale count enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 compare A, 2 compare B, 3 flag clear) |
| bus_wdata | input | 8 | Register write data |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| match_a_flag | output | 1 | Channel A compare-match flag |
| match_b_flag | output | 1 | Channel B compare-match flag |
| wave_a | output | 1 | Channel A waveform |
| wave_a_en | output | 1 | Channel A output enable |
| wave_b | output | 1 | Channel B waveform |
| wave_b_en | output | 1 | Channel B output enable |

## Verification
The bound checker watches several rules on every cycle: the count holds when there is no tick, mode 0 overflows and wraps, clear-on-compare returns to zero at the channel A value, phase-correct turns around at the top, a tick at the compare value raises the match flag, and compare writes take effect at once in the non-PWM modes. Other behaviours need the bench's long scenarios. These are the deferred activation of shadowed values at the wrap or top point, the waveform levels across the wrap and the up and down slopes, the overflow at the bottom of the phase-correct slope, and flag clearing that leaves neighbouring flags alone.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PHASE  = 2'd1,
    MODE_CTC    = 2'd2,
    MODE_FAST   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_CLEAR  = 2'd2,
    OUT_SET    = 2'd3
  } out_mode_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP_A = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMP_B = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd3;

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_we,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DW-1:0]           bus_wdata,
  input  logic                    set_ovf,
  input  logic [NUM_CH-1:0]       set_match,
  output cnt_mode_e               mode,
  output logic [NUM_CH-1:0][1:0]  out_mode,
  output logic [NUM_CH-1:0]       cmp_we,
  output logic                    ovf_flag,
  output logic [NUM_CH-1:0]       match_flag
);

  localparam int unsigned FW = NUM_CH + 1;

  logic [7:0]    ctrl_q, ctrl_d;
  logic [FW-1:0] flag_q, flag_d;
  logic [FW-1:0] flag_set, flag_clr;

  always_comb begin
    ctrl_d = ctrl_q;
    if (bus_we && bus_addr == ADDR_CTRL) ctrl_d = bus_wdata[7:0];
  end

  assign flag_set = {set_match, set_ovf};
  assign flag_clr = (bus_we && bus_addr == ADDR_FLAGS) ? bus_wdata[FW-1:0] : '0;

  always_comb begin
    flag_d = flag_set | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  assign mode        = cnt_mode_e'(ctrl_q[1:0]);
  assign out_mode[0] = ctrl_q[7:6];
  assign out_mode[1] = ctrl_q[5:4];
  assign cmp_we[0]   = bus_we && (bus_addr == ADDR_CMP_A);
  assign cmp_we[1]   = bus_we && (bus_addr == ADDR_CMP_B);
  assign ovf_flag    = flag_q[0];
  assign match_flag  = flag_q[FW-1:1];

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] ctc_top,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             at_max,
  output logic             ovf_ev,
  output logic             upd_ev
);

  localparam logic [CNT_W-1:0] ZERO  = '0;
  localparam logic [CNT_W-1:0] ONE   = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] MAX   = '1;
  localparam logic [CNT_W-1:0] MAXM1 = MAX - ONE;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = (mode == MODE_PHASE) ? dir_q : 1'b0;
    if (tick) begin
      unique case (mode)
        MODE_PHASE: begin
          if (!dir_q) begin
            if (cnt_q == MAX) begin
              cnt_d = MAXM1;
              dir_d = 1'b1;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == ZERO) begin
              cnt_d = ONE;
              dir_d = 1'b0;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        MODE_CTC:  cnt_d = (cnt_q == ctc_top) ? ZERO : cnt_q + ONE;
        default:   cnt_d = cnt_q + ONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign count    = cnt_q;
  assign dir_down = dir_q;
  assign at_max   = tick && (cnt_q == MAX);
  assign ovf_ev   = (mode == MODE_PHASE) ? (tick && dir_q && cnt_q == ZERO) : at_max;
  assign upd_ev   = (mode == MODE_PHASE || mode == MODE_FAST) && at_max;

endmodule

// File: rtl/pwm_tmr_cmpbuf.sv
module pwm_tmr_cmpbuf #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             buffered,
  input  logic             upd_ev,
  output logic [CNT_W-1:0] active
);

  logic [CNT_W-1:0] shd_q, shd_d;
  logic [CNT_W-1:0] act_q, act_d;

  always_comb begin
    shd_d = wr ? wr_val : shd_q;
    act_d = act_q;
    if (wr && !buffered)        act_d = wr_val;
    else if (buffered && upd_ev) act_d = shd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave
  import pwm_tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      match,
  input  logic      wrap_ev,
  input  logic      dir_down,
  input  cnt_mode_e mode,
  input  logic [1:0] out_mode,
  output logic      wave,
  output logic      wave_en
);

  out_mode_e om;
  logic      lvl_q, lvl_d;
  logic      set_lvl;

  assign om      = out_mode_e'(out_mode);
  assign set_lvl = (om == OUT_SET);

  always_comb begin
    lvl_d = lvl_q;
    unique case (om)
      OUT_OFF:    lvl_d = lvl_q;
      OUT_TOGGLE: if (match) lvl_d = ~lvl_q;
      default: begin
        unique case (mode)
          MODE_FAST: begin
            if (wrap_ev)    lvl_d = ~set_lvl;
            else if (match) lvl_d = set_lvl;
          end
          MODE_PHASE: begin
            if (match) lvl_d = dir_down ? ~set_lvl : set_lvl;
          end
          default: begin
            if (match) lvl_d = set_lvl;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign wave_en = (om != OUT_OFF);
  assign wave    = wave_en & lvl_q;

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             match_a_flag,
  output logic             match_b_flag,
  output logic             wave_a,
  output logic             wave_a_en,
  output logic             wave_b,
  output logic             wave_b_en
);

  logic [1:0]              rst_pipe;
  logic                    rst_int_n;
  cnt_mode_e               ctrl_mode;
  logic [NUM_CH-1:0][1:0]  out_mode;
  logic [NUM_CH-1:0]       cmp_we;
  logic [NUM_CH-1:0]       match_flag;
  logic [NUM_CH-1:0]       match_ev;
  logic [NUM_CH-1:0]       wave_vec;
  logic [NUM_CH-1:0]       wave_en_vec;
  logic [CNT_W-1:0]        act_cmp [NUM_CH];
  logic [CNT_W-1:0]        act_a;
  logic                    dir_down, at_max, ovf_ev, upd_ev, buffered;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pwm_tmr_regs #(.DW(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .set_ovf    (ovf_ev),
    .set_match  (match_ev),
    .mode       (ctrl_mode),
    .out_mode   (out_mode),
    .cmp_we     (cmp_we),
    .ovf_flag   (ovf_flag),
    .match_flag (match_flag)
  );

  assign act_a = act_cmp[0];

  pwm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (tick),
    .mode     (ctrl_mode),
    .ctc_top  (act_a),
    .count    (count),
    .dir_down (dir_down),
    .at_max   (at_max),
    .ovf_ev   (ovf_ev),
    .upd_ev   (upd_ev)
  );

  assign buffered = (ctrl_mode == MODE_PHASE) || (ctrl_mode == MODE_FAST);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwm_tmr_cmpbuf #(.CNT_W(CNT_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .wr       (cmp_we[ch]),
      .wr_val   (bus_wdata),
      .buffered (buffered),
      .upd_ev   (upd_ev),
      .active   (act_cmp[ch])
    );

    assign match_ev[ch] = tick && (count == act_cmp[ch]);

    pwm_tmr_wave u_wave (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .match    (match_ev[ch]),
      .wrap_ev  (at_max),
      .dir_down (dir_down),
      .mode     (ctrl_mode),
      .out_mode (out_mode[ch]),
      .wave     (wave_vec[ch]),
      .wave_en  (wave_en_vec[ch])
    );
  end

  assign match_a_flag = match_flag[0];
  assign match_b_flag = match_flag[1];
  assign wave_a       = wave_vec[0];
  assign wave_a_en    = wave_en_vec[0];
  assign wave_b       = wave_vec[1];
  assign wave_b_en    = wave_en_vec[1];

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] act_a,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             ovf_flag,
  input logic             match_a_flag
);

  localparam logic [CNT_W-1:0] MAX   = '1;
  localparam logic [CNT_W-1:0] MAXM1 = MAX - {{(CNT_W-1){1'b0}}, 1'b1};

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R3
  normal_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd0 && count == MAX) |=> (ovf_flag && count == '0));

  // R4
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd2 && count == act_a) |=> (count == '0));

  // R6
  phase_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd1 && count == MAX) |=> (count == MAXM1));

  // R8
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == act_a) |=> match_a_flag);

  // R7
  imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1 && (mode == 2'd0 || mode == 2'd2))
      |=> (act_a == $past(bus_wdata)));

endmodule

bind pwm_timer8 pwm_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .tick         (tick),
  .mode         (ctrl_mode),
  .count        (count),
  .act_a        (act_a),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .ovf_flag     (ovf_flag),
  .match_a_flag (match_a_flag)
);

// File: tb/pwm_timer8_tb.sv
module pwm_timer8_tb;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] count;
  logic       ovf_flag, match_a_flag, match_b_flag;
  logic       wave_a, wave_a_en, wave_b, wave_b_en;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  pwm_timer8 u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .count        (count),
    .ovf_flag     (ovf_flag),
    .match_a_flag (match_a_flag),
    .match_b_flag (match_b_flag),
    .wave_a       (wave_a),
    .wave_a_en    (wave_a_en),
    .wave_b       (wave_b),
    .wave_b_en    (wave_b_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  com;
    logic [7:0]  cmp;
    logic [15:0] ticks;
    logic [7:0]  cnt;
    logic        wave;
    logic        ovf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 8'd10,  16'd11,  8'd11,  1'b1, 1'b0, 4'd3 },  // R3 toggle at match
    '{2'd0, 2'd1, 8'd10,  16'd10,  8'd10,  1'b0, 1'b0, 4'd9 },  // R9 one tick short
    '{2'd0, 2'd1, 8'd0,   16'd256, 8'd0,   1'b1, 1'b1, 4'd3 },  // R3 full wrap
    '{2'd2, 2'd1, 8'd5,   16'd6,   8'd0,   1'b1, 1'b0, 4'd4 },  // R4 clear at top
    '{2'd2, 2'd1, 8'd5,   16'd8,   8'd2,   1'b1, 1'b0, 4'd4 },  // R4 second period
    '{2'd2, 2'd3, 8'd3,   16'd4,   8'd0,   1'b1, 1'b0, 4'd10},  // R10 set on match
    '{2'd3, 2'd2, 8'd20,  16'd256, 8'd0,   1'b1, 1'b1, 4'd11},  // R11 set at wrap
    '{2'd3, 2'd2, 8'd20,  16'd277, 8'd21,  1'b0, 1'b1, 4'd5 },  // R5 shadow active
    '{2'd3, 2'd3, 8'd20,  16'd277, 8'd21,  1'b1, 1'b1, 4'd11},  // R11 inverted
    '{2'd1, 2'd2, 8'd100, 16'd410, 8'd100, 1'b0, 1'b0, 4'd6 },  // R6 down slope
    '{2'd1, 2'd2, 8'd100, 16'd411, 8'd99,  1'b1, 1'b0, 4'd12},  // R12 down match sets
    '{2'd1, 2'd2, 8'd100, 16'd611, 8'd101, 1'b0, 1'b1, 4'd12}   // R12 up match clears
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    tick      = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = 2'd0;
    bus_wdata = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flags", {ovf_flag, match_a_flag, match_b_flag}, 0);
    chk("R1 waves", {wave_a, wave_a_en, wave_b, wave_b_en}, 0);
    // R1 field layout: A output mode in 7:6, B in 5:4
    bus_write(2'd0, 8'h80);
    chk("R1 A enable", {wave_a_en, wave_b_en}, 2'b10);
    bus_write(2'd0, 8'h30);
    chk("R1 B enable", {wave_a_en, wave_b_en}, 2'b01);

    // table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      do_reset();
      bus_write(2'd0, {VECS[i].com, 4'b0000, VECS[i].mode});
      bus_write(2'd1, VECS[i].cmp);
      run_ticks(int'(VECS[i].ticks));
      chk({tag, " count"}, count, VECS[i].cnt);
      chk({tag, " wave_a"}, wave_a, VECS[i].wave);
      chk({tag, " ovf"}, ovf_flag, VECS[i].ovf);
    end

    // R2 no tick, no count
    do_reset();
    run_ticks(5);
    repeat (10) @(negedge clk);
    chk("R2 hold", count, 5);

    // R7 immediate compare write in mode 0
    do_reset();
    bus_write(2'd0, 8'h40);
    bus_write(2'd1, 8'd200);
    run_ticks(5);
    bus_write(2'd1, 8'd6);
    run_ticks(2);
    chk("R7 count", count, 7);
    chk("R7 wave", wave_a, 1);

    // R5 write mid-period stays in shadow
    do_reset();
    bus_write(2'd0, 8'h83);
    bus_write(2'd1, 8'd20);
    run_ticks(256);
    bus_write(2'd1, 8'd50);
    run_ticks(21);
    chk("R5 old compare used", wave_a, 0);

    // R8 / R9 flags and disconnected output
    do_reset();
    bus_write(2'd2, 8'd7);
    run_ticks(256);
    chk("R8 all flags", {ovf_flag, match_a_flag, match_b_flag}, 3'b111);
    chk("R9 off", {wave_a, wave_a_en}, 0);
    bus_write(2'd3, 8'h01);
    chk("R8 clear ovf only", {ovf_flag, match_a_flag, match_b_flag}, 3'b011);
    bus_write(2'd3, 8'h06);
    chk("R8 clear rest", {ovf_flag, match_a_flag, match_b_flag}, 3'b000);

    // R8 set wins over clear (CTC with top 0 matches every tick)
    do_reset();
    bus_write(2'd0, 8'h02);
    @(negedge clk);
    tick = 1'b1;
    bus_write(2'd3, 8'h02);
    chk("R8 set beats clear", match_a_flag, 1);
    chk("R4 top zero", count, 0);
    tick = 1'b0;

    // R10 channel B set in mode 0
    do_reset();
    bus_write(2'd0, 8'h30);
    bus_write(2'd2, 8'd7);
    run_ticks(8);
    chk("R10 wave_b", wave_b, 1);
    chk("R10 flag_b", match_b_flag, 1);
    chk("R10 wave_a idle", wave_a, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule